// File: doc/BRIEF.md
# Programmable Reload Timer

The block combines a free-running 16-bit prescaler with an 8-bit programmable counter. The prescaler advances on every cycle in which the system clock enable `tick_i` is high. The enable is nominally 2^22 Hz. The upper byte of the prescaler is visible as a divider register. The counter steps at one of four rates, each taken from the low bits of that same prescaler. When the counter wraps past 0xFF it is reloaded from a modulo register, and a single-cycle interrupt request is raised.

Software reaches four byte-wide registers through a synchronous address/data bus with separate read and write strobes:

| Address | Register |
|---------|----------|
| 0xFF04 | divider |
| 0xFF05 | counter |
| 0xFF06 | modulo |
| 0xFF07 | control |

In the control register, bit 2 is the run enable and bits 1:0 select the rate. Read data is registered and appears one cycle after the read strobe.

Top module: `reload_timer`

## Requirements
- R1: After reset the divider, counter and modulo registers read 0x00, the control register reads 0xF8 and irq_o is low.
- R2: The prescaler advances by one on each clock in which tick_i is high and holds otherwise. The divider register (0xFF04) reads prescaler bits 15:8, so after W ticks from a clear it reads (W>>8)&0xFF.
- R3: Any write to 0xFF04 clears the whole 16-bit prescaler to zero, whatever the data written, and the divider then reads 0x00.
- R4: With run enabled, control bits 1:0 pick the increment period in ticks: 00 gives 1024, 01 gives 16, 10 gives 64 and 11 gives 256. Counting from a prescaler clear, the counter increments on tick numbers P, 2P, 3P and so on, so after W ticks it has incremented floor(W/P) times.
- R5: Control bit 2 = 1 runs the counter. With bit 2 = 0 the counter holds its value while the prescaler and divider keep advancing.
- R6: An increment from 0xFF loads the counter with the modulo value held at that step. irq_o is then high for exactly the one following cycle.
- R7: A bus write to the counter (0xFF05) in the same cycle as an increment takes precedence. The counter takes the written value and no interrupt is raised, even when the counter held 0xFF.
- R8: Control bits 7:3 always read as 1, and bits 2:0 read back as written.
- R9: The counter and modulo registers read back the last value written. rdata_o updates on the clock edge where rd_i is high. An address outside 0xFF04 to 0xFF07 reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base-rate clock enable (2^22 Hz nominal) |
| addr_i | input | 16 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Timer overflow interrupt request, one cycle |

## Verification
The assertions assume that increments on a running counter arrive at least two cycles apart. This holds because the shortest period is 16 ticks and tick_i is high at most once per clock. They also assume the base address is a multiple of four, so that the low two address bits select the register.

The stimulus performs every register set-up and every read with tick_i held low, which freezes the prescaler and the counter. The bench can therefore count exactly how many ticks each run window contains. The one deliberate collision between a counter write and an increment is placed by counting ticks from a divider clear.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned N_RATES = 4;

  typedef enum logic [1:0] {
    REG_DIV = 2'd0,
    REG_CNT = 2'd1,
    REG_MOD = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  // Number of low prescaler bits that must all be one for a step at each rate.
  function automatic int unsigned rate_bits(input int unsigned sel);
    case (sel)
      0:       return 10;
      1:       return 4;
      2:       return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/rtmr_prescaler.sv
module rtmr_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clear_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_o <= '0;
    else if (clear_i) count_o <= '0;
    else if (tick_i)  count_o <= count_o + 1'b1;
  end

  a_r3_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> count_o == '0);

  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clear_i) |=> $stable(count_o));
endmodule

// File: rtl/rtmr_rate_tap.sv
module rtmr_rate_tap #(
  parameter int unsigned W = 16
) (
  input  logic         tick_i,
  input  logic         run_i,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] count_i,
  output logic         step_o
);
  import rtmr_pkg::*;

  logic [N_RATES-1:0] wrap;

  for (genvar g = 0; g < N_RATES; g++) begin : g_tap
    localparam int unsigned NB = rate_bits(g);
    assign wrap[g] = &count_i[NB-1:0];
  end

  assign step_o = tick_i & run_i & wrap[sel_i];
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         cnt_we_i,
  input  logic         mod_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] mod_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic at_max;
  assign at_max = (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= step_i & ~cnt_we_i & at_max;
      if (cnt_we_i)    cnt_o <= wdata_i;
      else if (step_i) cnt_o <= at_max ? mod_o : cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mod_o <= '0;
    else if (mod_we_i) mod_o <= wdata_i;
  end

  a_r6_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cnt_o == $past(mod_o));

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);

  a_r7_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(wdata_i)) && !ovf_o);

  a_r5_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cnt_we_i) |=> $stable(cnt_o) && !ovf_o);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned  ADDR_W = 16,
  parameter logic [15:0]  BASE   = 16'hFF04,
  parameter int unsigned  PSC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_o
);
  import rtmr_pkg::*;

  localparam int unsigned CTL_W = 3;

  logic             hit;
  reg_sel_e         sel;
  logic [PSC_W-1:0] psc;
  logic [CTL_W-1:0] ctl_q;
  logic [DATA_W-1:0] cnt, modv, div_view, rd_val;
  logic             step, div_we, cnt_we, mod_we, ctl_we;

  assign hit      = (addr_i[ADDR_W-1:2] == BASE[ADDR_W-1:2]);
  assign sel      = reg_sel_e'(addr_i[1:0]);
  assign div_we   = wr_i & hit & (sel == REG_DIV);
  assign cnt_we   = wr_i & hit & (sel == REG_CNT);
  assign mod_we   = wr_i & hit & (sel == REG_MOD);
  assign ctl_we   = wr_i & hit & (sel == REG_CTL);
  assign div_view = psc[PSC_W-1 -: DATA_W];

  rtmr_prescaler #(.W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .clear_i (div_we),
    .count_o (psc)
  );

  rtmr_rate_tap #(.W(PSC_W)) u_tap (
    .tick_i  (tick_i),
    .run_i   (ctl_q[2]),
    .sel_i   (ctl_q[1:0]),
    .count_i (psc),
    .step_o  (step)
  );

  rtmr_counter #(.W(DATA_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .cnt_we_i (cnt_we),
    .mod_we_i (mod_we),
    .wdata_i  (wdata_i),
    .cnt_o    (cnt),
    .mod_o    (modv),
    .ovf_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= wdata_i[CTL_W-1:0];
  end

  always_comb begin
    unique case (sel)
      REG_DIV: rd_val = div_view;
      REG_CNT: rd_val = cnt;
      REG_MOD: rd_val = modv;
      default: rd_val = {{(DATA_W-CTL_W){1'b1}}, ctl_q};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= hit ? rd_val : '1;
  end

  a_r8_ctl_high_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit && sel == REG_CTL) |=> rdata_o[7:3] == 5'h1f);

  a_r9_unmapped_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !hit) |=> rdata_o == 8'hff);

  a_r5_stopped_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[2] && !ctl_we) |=> !irq_o);
endmodule

// File: tb/sim_reload_timer.sv
module sim_reload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [15:0] addr = 16'h0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = 8'h0;
  logic [7:0] rdata;
  logic irq;

  int total = 0, bad = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reload_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always @(negedge clk) if (rst_n && irq) irq_cnt++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic run_ticks(input int w);
    @(negedge clk); tick = 1'b1;
    repeat (w) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic int period(input int s);
    case (s)
      0: return 1024;
      1: return 16;
      2: return 64;
      default: return 256;
    endcase
  endfunction

  task automatic run_case(input string req, input int ctl, input int start,
                          input int modv, input int w);
    logic [7:0] v;
    int exp_v, exp_irq, incs, base;
    bus_wr(16'hFF07, ctl[7:0]);
    bus_wr(16'hFF06, modv[7:0]);
    bus_wr(16'hFF05, start[7:0]);
    bus_wr(16'hFF04, 8'h5a);
    base = irq_cnt;
    run_ticks(w);
    incs = ctl[2] ? w / period(ctl & 3) : 0;
    exp_v = start; exp_irq = 0;
    for (int i = 0; i < incs; i++) begin
      if (exp_v == 255) begin exp_v = modv; exp_irq++; end
      else exp_v++;
    end
    bus_rd(16'hFF05, v); check({req, " counter"}, v, exp_v);
    bus_rd(16'hFF04, v); check("R2 divider", v, (w >> 8) & 255);
    check({req, " irq count"}, irq_cnt - base, exp_irq);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1; bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq", irq, 0);
    bus_rd(16'hFF04, v); check("R1 divider", v, 8'h00);
    bus_rd(16'hFF05, v); check("R1 counter", v, 8'h00);
    bus_rd(16'hFF06, v); check("R1 modulo", v, 8'h00);
    bus_rd(16'hFF07, v); check("R1 control", v, 8'hf8);

    // R8 readback over all low control values
    for (int c = 0; c < 8; c++) begin
      bus_wr(16'hFF07, 8'(c) | 8'h50);
      bus_rd(16'hFF07, v); check("R8 control", v, 8'hf8 | c);
    end
    // R9 readback and unmapped
    bus_wr(16'hFF06, 8'ha7); bus_rd(16'hFF06, v); check("R9 modulo", v, 8'ha7);
    bus_wr(16'hFF05, 8'h3c); bus_rd(16'hFF05, v); check("R9 counter", v, 8'h3c);
    bus_rd(16'hFF08, v); check("R9 unmapped", v, 8'hff);
    bus_rd(16'h0005, v); check("R9 unmapped", v, 8'hff);

    // R2 / R3 divider advance and clear
    bus_wr(16'hFF07, 8'h00);
    bus_wr(16'hFF04, 8'h00);
    run_ticks(700);
    bus_rd(16'hFF04, v); check("R2 divider", v, 700 >> 8);
    bus_wr(16'hFF04, 8'hff);
    bus_rd(16'hFF04, v); check("R3 divider cleared", v, 0);

    // R4 / R6 rate sweep
    run_case("R4 rate00", 8'h04, 8'hfd, 8'hf0, 5000);
    run_case("R4 rate01", 8'h05, 8'h00, 8'h80, 5000);
    run_case("R4 rate10", 8'h06, 8'hc0, 8'h10, 9000);
    run_case("R4 rate11", 8'h07, 8'h00, 8'hfe, 20000);
    run_case("R6 reload ff", 8'h05, 8'hf0, 8'hff, 8000);
    run_case("R6 boundary", 8'h05, 8'hff, 8'h21, 16);
    run_case("R6 before boundary", 8'h05, 8'hff, 8'h21, 15);
    // R5 stopped
    run_case("R5 stopped", 8'h01, 8'h33, 8'h00, 3000);
    run_case("R5 stopped", 8'h03, 8'hff, 8'h00, 4096);

    // R7 write collides with increment from 0xff
    bus_wr(16'hFF07, 8'h05);
    bus_wr(16'hFF06, 8'h77);
    bus_wr(16'hFF05, 8'hff);
    bus_wr(16'hFF04, 8'h00);
    base = irq_cnt;
    @(negedge clk); tick = 1'b1;
    repeat (15) @(negedge clk);
    addr = 16'hFF05; wdata = 8'h42; wr = 1'b1;
    @(negedge clk); wr = 1'b0; tick = 1'b0;
    @(negedge clk);
    check("R7 no irq", irq_cnt - base, 0);
    bus_rd(16'hFF05, v); check("R7 counter", v, 8'h42);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule